// File: doc/BRIEF.md
# Receive FIFO Interrupt Controller

This block produces the receiver interrupt indications of a 16550-style serial port from the state of its receive FIFO. It watches the FIFO fill count, a strobe for each character written into the FIFO, a strobe for each CPU read, and a pending line error flag. From these it derives one interrupt line, a 4-bit identification code and a data-ready flag. The FIFO storage and the serial shifter sit outside it.

Three sources are ranked. A pending line error comes first. The FIFO reaching its programmed fill threshold comes next. The third is a character timeout: data has sat in the FIFO for four character times with neither a new arrival nor a CPU read. The timeout is measured in 16x baud ticks, so its length follows both the baud rate and the frame format (data bits, parity, one or two stop bits). Interrupts are raised only while both the FIFO enable and the receive interrupt enable are set.

Top module: `rx_fifo_irq_ctrl`

## Requirements
- R1: When `fifo_en_i` or `rx_irq_en_i` is 0, `irq_o` is 0 and `iid_o` is 4'h1, whatever the other inputs are.
- R2: With both enables set and no line error, `iid_o` is 4'h4 whenever `fifo_count_i` is at or above the threshold chosen by `trig_sel_i` (00 = 1, 01 = 4, 10 = 8, 11 = 14 for a 16-entry FIFO). It leaves 4'h4 in the same cycle the count drops below the threshold.
- R3: With both enables set, `line_err_i` = 1 gives `iid_o` = 4'h6, and this outranks every other source.
- R4: `data_ready_o` is 1 in the cycle after a `char_push_i` strobe. It returns to 0 in the cycle after the count is 0 with no strobe present.
- R5: A timeout (`iid_o` = 4'hC) is reported once the FIFO has held data for four character times of `baud_tick_i` pulses with no push and no pop. It ranks below the threshold indication, and it is never reported while the count is 0.
- R6: One character time is 16 ticks × (7 + `word_len_i` + `parity_en_i` + `two_stop_i`). Here `word_len_i` 0..3 selects 5..8 data bits and `two_stop_i` adds the second stop bit. The timeout therefore fires after exactly 4× that many ticks and not one tick earlier.
- R7: Before a timeout has fired, a push or a pop restarts the timeout count from zero.
- R8: A pop clears a pending timeout in the next cycle and restarts the count. An empty FIFO also clears it.
- R9: `irq_o` is 1 exactly when `iid_o` is not 4'h1. With nothing pending, `iid_o` is 4'h1.
- R10: After reset, `irq_o` is 0, `iid_o` is 4'h1 and `data_ready_o` is 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | FIFO enable |
| rx_irq_en_i | input | 1 | Receive interrupt enable |
| trig_sel_i | input | 2 | Fill threshold select |
| word_len_i | input | 2 | Data bits minus 5 |
| parity_en_i | input | 1 | Parity bit present in the frame |
| two_stop_i | input | 1 | Second stop bit present |
| baud_tick_i | input | 1 | One-cycle strobe at 16x the baud rate |
| fifo_count_i | input | CNT_W | Current FIFO fill level |
| char_push_i | input | 1 | Strobe: one character written into the FIFO |
| char_pop_i | input | 1 | Strobe: CPU read one character |
| line_err_i | input | 1 | Line error pending |
| irq_o | output | 1 | Receiver interrupt request |
| iid_o | output | 4 | Identification: 1 none, 6 line error, 4 threshold, C timeout |
| data_ready_o | output | 1 | Data-ready flag |

## Verification
The assertions assume that push and pop are single-cycle strobes and that `fifo_count_i` reflects the FIFO one cycle after each strobe. They also assume the count never exceeds the FIFO depth. The bench drives the count that way in every directed sequence, and keeps the random patterns within 0 to 16. The random phase never pulses the baud tick, so no timeout can arise there. Before each timeout sequence the bench empties the FIFO for a cycle, so a change of frame format never meets a partly run timer.

// File: rtl/rfic_pkg.sv
package rfic_pkg;
  typedef enum logic [3:0] {
    IID_NONE = 4'h1,
    IID_LSR  = 4'h6,
    IID_RDA  = 4'h4,
    IID_TMO  = 4'hC
  } iid_e;

  // fill threshold for a 2-bit select code
  function automatic int trig_level(int depth, int code);
    case (code)
      0:       return 1;
      1:       return depth / 4;
      2:       return depth / 2;
      default: return depth - 2;
    endcase
  endfunction
endpackage

// File: rtl/rfic_trig_cmp.sv
module rfic_trig_cmp #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input  logic [1:0]       trig_sel_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             at_level_o
);
  logic [CNT_W-1:0] lvl [4];

  for (genvar g = 0; g < 4; g++) begin : g_lvl
    assign lvl[g] = CNT_W'(rfic_pkg::trig_level(DEPTH, g));
  end

  assign at_level_o = count_i >= lvl[trig_sel_i];
endmodule

// File: rtl/rfic_dr_flag.sv
module rfic_dr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic nonempty_i,
  output logic dr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         dr_o <= 1'b0;
    else if (push_i)     dr_o <= 1'b1;
    else if (!nonempty_i) dr_o <= 1'b0;
  end
endmodule

// File: rtl/rfic_char_timer.sv
module rfic_char_timer #(
  parameter int BIT_TICKS = 16,
  parameter int TO_CHARS  = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       baud_tick_i,
  input  logic       push_i,
  input  logic       pop_i,
  input  logic       nonempty_i,
  input  logic [1:0] word_len_i,
  input  logic       parity_en_i,
  input  logic       two_stop_i,
  output logic       to_pend_o
);
  localparam int TICK_SCALE = BIT_TICKS * TO_CHARS;
  localparam int MAX_THR    = TICK_SCALE * 12;
  localparam int TMR_W      = $clog2(MAX_THR + 1);

  logic [3:0]       frame_bits;
  logic [TMR_W-1:0] thr, tmr;
  logic             expired;

  // start + 5 data + 1 stop = 7 fixed bits
  assign frame_bits = 4'd7 + {2'b00, word_len_i} + {3'b000, parity_en_i} + {3'b000, two_stop_i};
  assign thr        = TMR_W'(frame_bits) * TMR_W'(TICK_SCALE);
  assign expired    = tmr == thr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            tmr <= '0;
    else if (push_i || pop_i || !nonempty_i) tmr <= '0;
    else if (baud_tick_i && !expired)       tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  to_pend_o <= 1'b0;
    else if (pop_i || !nonempty_i) to_pend_o <= 1'b0;
    else if (expired)             to_pend_o <= 1'b1;
  end
endmodule

// File: rtl/rfic_irq_prio.sv
module rfic_irq_prio
  import rfic_pkg::*;
(
  input  logic       en_i,
  input  logic       lsr_i,
  input  logic       rda_i,
  input  logic       to_i,
  input  logic       nonempty_i,
  output logic       irq_o,
  output logic [3:0] iid_o
);
  iid_e id;

  always_comb begin
    id = IID_NONE;
    if (en_i) begin
      if (lsr_i)                  id = IID_LSR;
      else if (rda_i)             id = IID_RDA;
      else if (to_i && nonempty_i) id = IID_TMO;
    end
  end

  assign iid_o = id;
  assign irq_o = id != IID_NONE;
endmodule

// File: rtl/rx_fifo_irq_ctrl.sv
module rx_fifo_irq_ctrl #(
  parameter int DEPTH     = 16,
  parameter int BIT_TICKS = 16,
  parameter int TO_CHARS  = 4,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             rx_irq_en_i,
  input  logic [1:0]       trig_sel_i,
  input  logic [1:0]       word_len_i,
  input  logic             parity_en_i,
  input  logic             two_stop_i,
  input  logic             baud_tick_i,
  input  logic [CNT_W-1:0] fifo_count_i,
  input  logic             char_push_i,
  input  logic             char_pop_i,
  input  logic             line_err_i,
  output logic             irq_o,
  output logic [3:0]       iid_o,
  output logic             data_ready_o
);
  logic nonempty, at_level, to_pend, en;

  assign nonempty = fifo_count_i != '0;
  assign en       = fifo_en_i & rx_irq_en_i;

  rfic_trig_cmp #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_trig (
    .trig_sel_i (trig_sel_i),
    .count_i    (fifo_count_i),
    .at_level_o (at_level)
  );

  rfic_dr_flag u_dr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (char_push_i),
    .nonempty_i (nonempty),
    .dr_o       (data_ready_o)
  );

  rfic_char_timer #(.BIT_TICKS(BIT_TICKS), .TO_CHARS(TO_CHARS)) u_tmr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .baud_tick_i (baud_tick_i),
    .push_i      (char_push_i),
    .pop_i       (char_pop_i),
    .nonempty_i  (nonempty),
    .word_len_i  (word_len_i),
    .parity_en_i (parity_en_i),
    .two_stop_i  (two_stop_i),
    .to_pend_o   (to_pend)
  );

  rfic_irq_prio u_prio (
    .en_i       (en),
    .lsr_i      (line_err_i),
    .rda_i      (at_level),
    .to_i       (to_pend),
    .nonempty_i (nonempty),
    .irq_o      (irq_o),
    .iid_o      (iid_o)
  );
endmodule

// File: rtl/rx_fifo_irq_ctrl_chk.sv
module rx_fifo_irq_ctrl_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fifo_en_i,
  input logic             rx_irq_en_i,
  input logic             line_err_i,
  input logic             char_push_i,
  input logic             char_pop_i,
  input logic [CNT_W-1:0] fifo_count_i,
  input logic             irq_o,
  input logic [3:0]       iid_o,
  input logic             data_ready_o
);
  AST_GATED_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fifo_en_i && rx_irq_en_i) |-> !irq_o); // R1
  AST_LSR_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en_i && rx_irq_en_i && line_err_i) |-> iid_o == 4'h6); // R3
  AST_DR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_push_i |=> data_ready_o); // R4
  AST_DR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_count_i == '0 && !char_push_i) |=> !data_ready_o); // R4
  AST_TO_HAS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iid_o == 4'hC |-> fifo_count_i != '0); // R5
  AST_TO_POP_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_pop_i |=> iid_o != 4'hC); // R8
  AST_IRQ_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (iid_o != 4'h1)); // R9
endmodule

bind rx_fifo_irq_ctrl rx_fifo_irq_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fifo_en_i    (fifo_en_i),
  .rx_irq_en_i  (rx_irq_en_i),
  .line_err_i   (line_err_i),
  .char_push_i  (char_push_i),
  .char_pop_i   (char_pop_i),
  .fifo_count_i (fifo_count_i),
  .irq_o        (irq_o),
  .iid_o        (iid_o),
  .data_ready_o (data_ready_o)
);

// File: tb/rx_fifo_irq_ctrl_test.sv
`timescale 1ns/1ps
module rx_fifo_irq_ctrl_test;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             fe = 0, ie = 0, par = 0, two = 0, tick = 0, push = 0, pop = 0, err = 0;
  logic [1:0]       trig = 0, wl = 0;
  logic [CNT_W-1:0] cnt = '0;
  logic             irq, dr;
  logic [3:0]       iid;

  int checks = 0, fails = 0;
  bit done = 0;

  rx_fifo_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fe), .rx_irq_en_i(ie),
    .trig_sel_i(trig), .word_len_i(wl), .parity_en_i(par), .two_stop_i(two),
    .baud_tick_i(tick), .fifo_count_i(cnt), .char_push_i(push), .char_pop_i(pop),
    .line_err_i(err), .irq_o(irq), .iid_o(iid), .data_ready_o(dr)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int lvl_of(logic [1:0] t);
    case (t)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic int exp_iid(logic f, logic i, logic e, int c, logic [1:0] t, logic to);
    if (!(f && i)) return 1;
    if (e) return 6;
    if (c >= lvl_of(t)) return 4;
    if (to && c != 0) return 12;
    return 1;
  endfunction

  function automatic int thr_of(logic [1:0] w, logic p, logic s);
    return 4 * 16 * (7 + int'(w) + int'(p) + int'(s));
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_char();
    push = 1; cyc(1); push = 0; cnt = cnt + 1'b1;
  endtask

  task automatic pop_char();
    pop = 1; cyc(1); pop = 0; cnt = cnt - 1'b1;
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      tick = 1; cyc(1); tick = 0; cyc(1);
    end
  endtask

  task automatic empty_fifo();
    cnt = '0; cyc(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    cyc(3); rst_n = 1; cyc(1); #1;
    chk("R10 irq", irq, 0);
    chk("R10 iid", iid, 1);
    chk("R10 dr", dr, 0);

    // random level patterns, no baud ticks
    for (int n = 0; n < 300; n++) begin
      string tag;
      fe = 1'($urandom); ie = 1'($urandom);
      if (n % 3 == 0) begin fe = 1; ie = 1; end
      err = ($urandom % 5) == 0;
      cnt = CNT_W'($urandom % (DEPTH + 1));
      trig = 2'($urandom);
      cyc(1); #1;
      if (!(fe && ie)) tag = "R1";
      else if (err) tag = "R3";
      else if (int'(cnt) >= lvl_of(trig)) tag = "R2";
      else tag = "R9";
      chk(tag, iid, exp_iid(fe, ie, err, int'(cnt), trig, 1'b0));
      chk("R9 irq", irq, exp_iid(fe, ie, err, int'(cnt), trig, 1'b0) != 1);
    end

    // threshold edges
    fe = 1; ie = 1; err = 0;
    for (int t = 0; t < 4; t++) begin
      trig = 2'(t);
      cnt = CNT_W'(lvl_of(trig) - 1); cyc(1); #1;
      chk("R2 below", iid, 1);
      cnt = CNT_W'(lvl_of(trig)); cyc(1); #1;
      chk("R2 at", iid, 4);
    end
    cnt = 5'd16; err = 1; cyc(1); #1;
    chk("R3 over rda", iid, 6);
    fe = 0; cyc(1); #1;
    chk("R1 fifo off", irq, 0);
    chk("R1 fifo off iid", iid, 1);
    fe = 1; ie = 0; cyc(1); #1;
    chk("R1 irq off", irq, 0);
    ie = 1; err = 0;

    // data ready
    empty_fifo(); #1;
    chk("R4 empty", dr, 0);
    push_char(); #1;
    chk("R4 set", dr, 1);
    cyc(3); #1;
    chk("R4 hold", dr, 1);
    cnt = '0; cyc(1); #1;
    chk("R4 clear", dr, 0);

    // timeout, 8N1
    trig = 2'd3; wl = 2'd3; par = 0; two = 0;
    empty_fifo();
    push_char(); push_char();
    ticks(thr_of(wl, par, two) - 1); #1;
    chk("R6 early", iid, 1);
    ticks(1); #1;
    chk("R5 fire", iid, 12);
    chk("R5 irq", irq, 1);
    err = 1; cyc(1); #1;
    chk("R3 over timeout", iid, 6);
    err = 0; cnt = 5'd14; cyc(1); #1;
    chk("R5 below rda", iid, 4);
    cnt = 5'd2; cyc(1); #1;
    chk("R5 back", iid, 12);
    pop_char(); #1;
    chk("R8 pop clears", iid, 1);
    ticks(thr_of(wl, par, two) - 1); #1;
    chk("R8 restart", iid, 1);
    ticks(1); #1;
    chk("R8 refire", iid, 12);
    cnt = '0; cyc(1); #1;
    chk("R5 empty", iid, 1);
    cnt = 5'd1; cyc(1); #1;
    chk("R8 empty clears", iid, 1);

    // timeout, 5 bits, parity, 2 stop
    wl = 2'd0; par = 1; two = 1;
    empty_fifo();
    push_char();
    ticks(thr_of(wl, par, two) - 1); #1;
    chk("R6 2stop early", iid, 1);
    ticks(1); #1;
    chk("R6 2stop fire", iid, 12);

    // restart by push and pop
    wl = 2'd3; par = 0; two = 0;
    empty_fifo();
    push_char();
    ticks(thr_of(wl, par, two) - 10);
    push_char();
    ticks(thr_of(wl, par, two) - 1); #1;
    chk("R7 push restart", iid, 1);
    pop_char();
    ticks(thr_of(wl, par, two) - 1); #1;
    chk("R7 pop restart", iid, 1);
    ticks(1); #1;
    chk("R7 fire", iid, 12);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule